// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block turns the stored contents of a small display register file into time-multiplexed drive for common-cathode LED digits. It takes four digit registers, an eight-bit discrete-LED register, per-digit decode enables, a six-bit brightness level, a scan limit, a test flag and a shutdown flag. It produces one-hot digit-select lines and nine segment lines: seven for the a–g bars of the selected digit and two for the discrete LEDs tied to that digit's slot.

A divider derived from the system clock advances a PWM tick. Each digit slot is a short blanking guard followed by 64 PWM steps. The digits are visited in ascending order up to the scan limit, and then the scan wraps to digit 0. With the default divider and a 50 MHz clock, a four-digit frame repeats at about 780 Hz.

All outputs are registered. The scan counters keep running during shutdown, and the register contents sit outside the block, so the display comes back with the current data as soon as shutdown is released.

Top module: `seg_mux_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, every output is low. The scan then starts at digit 0, phase 0.
- R2: The PWM tick advances every `PRE_DIV` clocks. A digit slot lasts `GUARD_TICKS + 64` ticks. On the registered outputs, each slot is therefore `(GUARD_TICKS+64)*PRE_DIV` clocks long.
- R3: A scan limit value n (0 to 3) selects digits 0..n in ascending order, followed by a wrap to digit 0. Digits above n are never selected.
- R4: `dig_sel` has at most one bit high. Bit k high means digit k is being driven.
- R5: When digit k has decode off, `seg_ag[6:0]` equals bits 6..0 of that digit's register, with bit 6 driving segment a and bit 0 driving segment g. Bit 7 of the register has no effect.
- R6: When `decode_en[k]` is 1, bits 3..0 of digit k's register select a hexadecimal glyph (order a..g, bit 6..0): 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=5F, 7=70, 8=7F, 9=7B, A=77, b=1F, C=4E, d=3D, E=4F, F=47. Bits 7..4 have no effect.
- R7: During digit k's slot, `seg_x[0]` shows bit k of `led_reg` and `seg_x[1]` shows bit k+4, independent of the digit registers.
- R8: After the guard, the segment lines are enabled for `intensity+1` of the 64 steps, and are blanked for the rest of the slot.
- R9: During the first `GUARD_TICKS` ticks of every slot, all segment lines are low while `dig_sel` already shows the new digit.
- R10: With `disp_test` high, all nine segment lines are high for all 64 steps of every scanned slot, whatever the data, decode and intensity.
- R11: With `shutdown` high, all outputs are low, and shutdown overrides test. The scan position keeps advancing, so leaving shutdown resumes at the current position.
- R12: Outputs reflect the scan state and inputs sampled at the previous clock edge, with exactly one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| digit_regs | input | 8*N_DIGITS | Digit k's register at bits [8k+7:8k] |
| led_reg | input | 2*N_DIGITS | Discrete LED register |
| decode_en | input | N_DIGITS | Per-digit hex decode enable |
| intensity | input | 6 | Brightness level, lit steps = value+1 |
| scan_limit | input | 2 | Highest digit scanned |
| disp_test | input | 1 | Force all segments on |
| shutdown | input | 1 | Blank all outputs |
| dig_sel | output | N_DIGITS | One-hot digit select |
| seg_ag | output | 7 | Segments a..g (bit 6 = a) |
| seg_x | output | 2 | Discrete LEDs of the current slot |

## Verification
Raw data with bit 7 set, at full brightness over four digits, separates the no-decode path from the decoder and shows that bit 7 is dropped. All-decode data with junk in the high nibbles, at low brightness, shows both the font and the PWM cut-off. A mixed decode mask combined with scan limits 1 and 0 tells the per-digit selection apart from a global one, and shows the shortened scan sequence. A sweep of codes 0..F covers every glyph. Test mode at intensity 0, and shutdown with test on, separate the override priorities.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_W = 7;

  // Hex glyph in a..g order, bit 6 = a.
  function automatic logic [SEG_W-1:0] hex_glyph(input logic [3:0] code);
    logic [SEG_W-1:0] g;
    case (code)
      4'h0: g = 7'h7E;
      4'h1: g = 7'h30;
      4'h2: g = 7'h6D;
      4'h3: g = 7'h79;
      4'h4: g = 7'h33;
      4'h5: g = 7'h5B;
      4'h6: g = 7'h5F;
      4'h7: g = 7'h70;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h7B;
      4'hA: g = 7'h77;
      4'hB: g = 7'h1F;
      4'hC: g = 7'h4E;
      4'hD: g = 7'h3D;
      4'hE: g = 7'h4F;
      default: g = 7'h47;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int N_DIGITS    = 4,
  parameter int PRE_DIV     = 243,
  parameter int GUARD_TICKS = 2,
  parameter int PWM_STEPS   = 64,
  localparam int SLOT_TICKS = GUARD_TICKS + PWM_STEPS,
  localparam int PH_W       = $clog2(SLOT_TICKS),
  localparam int DG_W       = $clog2(N_DIGITS),
  localparam int PRE_W      = $clog2(PRE_DIV + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DG_W-1:0] scan_limit,
  output logic [PH_W-1:0] phase,
  output logic [DG_W-1:0] digit
);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SLOT_TICKS - 1);
  localparam logic [DG_W-1:0]  DG_LAST  = DG_W'(N_DIGITS - 1);

  logic [PRE_W-1:0] pre_cnt;
  logic             tick;
  logic             wrap_digit;

  assign tick       = (pre_cnt == PRE_LAST);
  assign wrap_digit = (digit >= scan_limit) || (digit == DG_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      phase   <= '0;
      digit   <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      if (phase == PH_LAST) begin
        phase <= '0;
        digit <= wrap_digit ? '0 : digit + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // R2: a tick inside the slot moves the phase by exactly one
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && phase != PH_LAST) |=> (phase == $past(phase) + 1'b1));

  // R3: leaving the slot of the limit digit returns to digit 0
  assert_scan_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && phase == PH_LAST && digit >= scan_limit) |=> (digit == '0));

  // R2: no tick means the scan position holds
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(phase) && $stable(digit)));
endmodule

// File: rtl/glyph_sel.sv
module glyph_sel
  import seg_pkg::*;
#(
  parameter int N_DIGITS = 4,
  localparam int DG_W    = $clog2(N_DIGITS)
) (
  input  logic [8*N_DIGITS-1:0] digit_regs,
  input  logic [N_DIGITS-1:0]   decode_en,
  input  logic [DG_W-1:0]       digit,
  output logic [SEG_W-1:0]      pattern
);
  logic [SEG_W-1:0] per_digit [N_DIGITS];

  for (genvar k = 0; k < N_DIGITS; k++) begin : g_dig
    logic [7:0] raw;
    assign raw = digit_regs[8*k +: 8];
    assign per_digit[k] = decode_en[k] ? hex_glyph(raw[3:0]) : raw[SEG_W-1:0];
  end

  assign pattern = per_digit[digit];
endmodule

// File: rtl/seg_mux_ctrl.sv
module seg_mux_ctrl
  import seg_pkg::*;
#(
  parameter int N_DIGITS    = 4,
  parameter int PRE_DIV     = 243,
  parameter int GUARD_TICKS = 2,
  parameter int PWM_STEPS   = 64,
  localparam int SLOT_TICKS = GUARD_TICKS + PWM_STEPS,
  localparam int PH_W       = $clog2(SLOT_TICKS),
  localparam int DG_W       = $clog2(N_DIGITS),
  localparam int INT_W      = $clog2(PWM_STEPS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [8*N_DIGITS-1:0] digit_regs,
  input  logic [2*N_DIGITS-1:0] led_reg,
  input  logic [N_DIGITS-1:0]   decode_en,
  input  logic [INT_W-1:0]      intensity,
  input  logic [DG_W-1:0]       scan_limit,
  input  logic                  disp_test,
  input  logic                  shutdown,
  output logic [N_DIGITS-1:0]   dig_sel,
  output logic [SEG_W-1:0]      seg_ag,
  output logic [1:0]            seg_x
);
  logic [PH_W-1:0]     phase;
  logic [DG_W-1:0]     digit;
  logic [SEG_W-1:0]    pattern;
  logic [PH_W-1:0]     active_step;
  logic                in_window;
  logic                lit;
  logic [N_DIGITS-1:0] sel_n;
  logic [SEG_W-1:0]    ag_n;
  logic [1:0]          x_n;

  scan_timer #(
    .N_DIGITS(N_DIGITS), .PRE_DIV(PRE_DIV),
    .GUARD_TICKS(GUARD_TICKS), .PWM_STEPS(PWM_STEPS)
  ) u_timer (
    .clk(clk), .rst(rst), .scan_limit(scan_limit),
    .phase(phase), .digit(digit)
  );

  glyph_sel #(.N_DIGITS(N_DIGITS)) u_glyph (
    .digit_regs(digit_regs), .decode_en(decode_en),
    .digit(digit), .pattern(pattern)
  );

  assign active_step = phase - PH_W'(GUARD_TICKS);
  assign in_window   = (phase >= PH_W'(GUARD_TICKS));
  assign lit         = in_window && (disp_test || active_step <= PH_W'(intensity));

  always_comb begin
    sel_n = '0;
    ag_n  = '0;
    x_n   = '0;
    if (!shutdown) begin
      sel_n[digit] = 1'b1;
      if (lit) begin
        ag_n = disp_test ? '1 : pattern;
        x_n  = disp_test ? 2'b11
                         : {led_reg[N_DIGITS + int'(digit)], led_reg[int'(digit)]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dig_sel <= '0;
      seg_ag  <= '0;
      seg_x   <= '0;
    end else begin
      dig_sel <= sel_n;
      seg_ag  <= ag_n;
      seg_x   <= x_n;
    end
  end

  // R4: never more than one digit driven
  assert_onehot_sel_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dig_sel));

  // R11: shutdown darkens every output on the next cycle
  assert_shutdown_dark_R11: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (dig_sel == '0 && seg_ag == '0 && seg_x == '0));

  // R9: guard phase of the timer gives blank segments
  assert_guard_blank_R9: assert property (@(posedge clk) disable iff (rst)
    (phase < PH_W'(GUARD_TICKS)) |=> (seg_ag == '0 && seg_x == '0));

  // R10: test mode inside the active window lights everything
  assert_test_full_R10: assert property (@(posedge clk) disable iff (rst)
    (disp_test && !shutdown && phase >= PH_W'(GUARD_TICKS))
      |=> (seg_ag == '1 && seg_x == 2'b11));
endmodule

// File: tb/tb_seg_mux_ctrl.sv
`timescale 1ns/1ps
module tb_seg_mux_ctrl;
  localparam int ND = 4;
  localparam int PD = 2;
  localparam int GT = 2;
  localparam int STEPS = 64;
  localparam int SLOT = GT + STEPS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] digit_regs = '0;
  logic [7:0]  led_reg = '0;
  logic [3:0]  decode_en = '0;
  logic [5:0]  intensity = '0;
  logic [1:0]  scan_limit = 2'd3;
  logic        disp_test = 1'b0;
  logic        shutdown = 1'b0;
  logic [3:0]  dig_sel;
  logic [6:0]  seg_ag;
  logic [1:0]  seg_x;

  int vectors = 0;
  int fails = 0;
  bit started = 0;

  seg_mux_ctrl #(.N_DIGITS(ND), .PRE_DIV(PD), .GUARD_TICKS(GT), .PWM_STEPS(STEPS)) dut (
    .clk(clk), .rst(rst), .digit_regs(digit_regs), .led_reg(led_reg),
    .decode_en(decode_en), .intensity(intensity), .scan_limit(scan_limit),
    .disp_test(disp_test), .shutdown(shutdown),
    .dig_sel(dig_sel), .seg_ag(seg_ag), .seg_x(seg_x)
  );

  always #10 clk = ~clk;

  function automatic logic [6:0] font(input int v);
    case (v)
      0: return 7'h7E;  1: return 7'h30;  2: return 7'h6D;  3: return 7'h79;
      4: return 7'h33;  5: return 7'h5B;  6: return 7'h5F;  7: return 7'h70;
      8: return 7'h7F;  9: return 7'h7B;  10: return 7'h77; 11: return 7'h1F;
      12: return 7'h4E; 13: return 7'h3D; 14: return 7'h4F; default: return 7'h47;
    endcase
  endfunction

  // Behavioural reference: integer position counters, expected outputs one cycle late
  int m_pre, m_ph, m_dg;
  logic [3:0] e_sel;
  logic [6:0] e_ag;
  logic [1:0] e_x;
  string tag_ag;

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_ph = 0; m_dg = 0;
      e_sel = '0; e_ag = '0; e_x = '0; tag_ag = "R1";
    end else begin
      bit on;
      logic [7:0] d;
      on = (m_ph >= GT) && (disp_test || (m_ph - GT) < intensity + 1);
      d = digit_regs[8*m_dg +: 8];
      e_sel = '0; e_ag = '0; e_x = '0;
      if (shutdown) tag_ag = "R11";
      else begin
        e_sel[m_dg] = 1'b1;
        if (m_ph < GT) tag_ag = "R9";
        else if (disp_test) tag_ag = "R10";
        else if (!on) tag_ag = "R8";
        else tag_ag = decode_en[m_dg] ? "R6" : "R5";
        if (on) begin
          if (disp_test) begin e_ag = '1; e_x = 2'b11; end
          else begin
            e_ag = decode_en[m_dg] ? font(int'(d[3:0])) : d[6:0];
            e_x  = {led_reg[m_dg+4], led_reg[m_dg]};
          end
        end
      end
      m_pre++;
      if (m_pre == PD) begin
        m_pre = 0; m_ph++;
        if (m_ph == SLOT) begin
          m_ph = 0;
          m_dg = (m_dg >= scan_limit) ? 0 : m_dg + 1;
        end
      end
    end
    started = 1;
  end

  // Compare away from the active edge (R12 latency, R2/R3/R4 selection)
  always @(negedge clk) if (started) begin
    vectors++;
    if (dig_sel !== e_sel) begin
      fails++;
      $display("FAIL R3 dig_sel actual=%b expected=%b t=%0t", dig_sel, e_sel, $time);
    end
    if (seg_ag !== e_ag) begin
      fails++;
      $display("FAIL %s seg_ag actual=%h expected=%h t=%0t", tag_ag, seg_ag, e_ag, $time);
    end
    if (seg_x !== e_x) begin
      fails++;
      $display("FAIL R7 seg_x actual=%b expected=%b t=%0t", seg_x, e_x, $time);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(5);                             // R1: reset state compared
    rst = 1'b0;
    // R5 R7 R8: raw data with bit 7 set, full brightness, four digits
    digit_regs = {8'hC1, 8'hB6, 8'h9B, 8'hFF}; led_reg = 8'hA5; intensity = 6'd63;
    run(600);
    // R6 R8: decode everywhere, junk high nibbles, low brightness
    decode_en = 4'hF; intensity = 6'd3;
    digit_regs = {8'hA7, 8'h5C, 8'hF2, 8'h90}; led_reg = 8'h3C;
    run(600);
    // R3 R6 R5: mixed decode, limit 1 then 0
    decode_en = 4'b0101; scan_limit = 2'd1; intensity = 6'd20;
    run(300);
    scan_limit = 2'd0;
    run(300);
    scan_limit = 2'd2;
    run(450);
    // R10: test overrides data and intensity 0
    scan_limit = 2'd3; intensity = 6'd0; disp_test = 1'b1;
    run(600);
    // R11: shutdown beats test, then resumes
    shutdown = 1'b1;
    run(300);
    shutdown = 1'b0; disp_test = 1'b0;
    run(300);
    // R6: sweep every glyph on digit 0 only
    scan_limit = 2'd0; decode_en = 4'h1; intensity = 6'd63;
    for (int v = 0; v < 16; v++) begin
      digit_regs[7:0] = 8'(8'h60 | v);
      run(140);
    end
    // R1: reset again mid-scan
    rst = 1'b1; run(4); rst = 1'b0; run(200);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule